// File: doc/BRIEF.md
# Serial ADC Sequencing Controller

This block sits on the host side of a 12-bit sampling converter. The converter is reached over a three-wire serial link plus a separate convert strobe. A single-cycle start request from the user side runs one complete conversion cycle, in this order:

1. The strobe drops briefly so that the converter samples its input.
2. The strobe rises and is held high for a programmable conversion wait.
3. The strobe falls and a setup gap follows.
4. Exactly twelve shift clocks run. During these clocks a 2-bit multiplexer configuration word goes out and the 12-bit result comes back at the same time.

When the last clock ends, the strobe goes high again and the converter rests in sleep. The result is then presented with a one-cycle valid flag.

All timing counts in ticks of one divider. The divider is reloaded with the value of `div_i` when a start is accepted, which gives a tick period of `div_i+1` system clocks (called P below). Each shift-clock half period is one tick. The conversion wait is `conv_wait_i+1` ticks. The setup gap and the sampling gap are each one tick. The configuration word sent during a transfer selects the input for the conversion that follows it.

Top module: `adc_seq_ctrl`

## Requirements
- R1: While reset is held, and afterwards until a start is accepted, the outputs are at rest: strobe high, shift clock low, data-out low, busy low, valid low and result zero.
- R2: On an accepted start, busy rises in the following cycle. The strobe is then low for exactly P cycles before it rises.
- R3: Once risen, the strobe stays high for exactly (conv_wait+1)·P cycles.
- R4: After the strobe falls, exactly P cycles pass before the first rising edge of the shift clock.
- R5: Each transfer has exactly 12 rising edges of the shift clock. Every high phase and every low phase between rises lasts exactly P cycles, and the clock idles low.
- R6: The controller samples the converter's data line at each rising edge of the shift clock, most significant bit first. `result_o` equals the 12-bit word the converter shifted out.
- R7: The data-out line carries cfg_i[1] at the first rising edge and cfg_i[0] at the second. It is low at the remaining ten rising edges, and it changes only while the shift clock is low.
- R8: The strobe rises in the same cycle as the last falling edge of the shift clock. In that cycle valid is high for one cycle and busy falls. The valid flag is seen (conv_wait+26)·P cycles after the accepting edge.
- R9: A start request that arrives while busy is ignored. No extra transfer follows, and that request's configuration is never sent.
- R10: `div_i`, `conv_wait_i` and `cfg_i` are captured when the start is accepted. Later changes to them have no effect on the running cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, sampled in idle only |
| cfg_i | input | 2 | Multiplexer configuration word for the next conversion |
| div_i | input | DIV_W | Tick period minus one, in system clocks |
| conv_wait_i | input | WAIT_W | Conversion hold minus one, in ticks |
| sdo_i | input | 1 | Serial data from the converter |
| conv_o | output | 1 | Convert strobe |
| sck_o | output | 1 | Shift clock |
| sdi_o | output | 1 | Serial configuration data to the converter |
| busy_o | output | 1 | A conversion cycle is running |
| valid_o | output | 1 | One-cycle pulse, result_o updated |
| result_o | output | 12 | Last conversion result |

## Verification
The hardest situation to bring about is a second start request that lands in the middle of a running cycle while the divider and wait inputs are also changing. A faulty design would then restart, queue the request, or stretch its phases. The stimulus fires such a request halfway through selected transfers, with a different configuration word and different timing inputs. It then checks three things: every phase length still matches the values captured at acceptance, the configuration bits seen at the first two rising clock edges belong to the original request, and only one valid pulse appears. Random words, divider values and waits cover the ordinary cycles. Directed cases add the all-ones word, the single-MSB word, the shortest timing (divider and wait at zero), and a long divider.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACQ,
    ST_CONV,
    ST_SETUP,
    ST_SCK_HI,
    ST_SCK_LO
  } seq_state_t;
endpackage

// File: rtl/adc_seq_tick.sv
// Tick generator: one pulse every div_i+1 cycles, phase restarted on demand.
module adc_seq_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             hit;

  assign hit    = (cnt_q == div_i);
  assign tick_o = hit && !restart_i;

  always_comb begin
    if (restart_i || hit) cnt_d = '0;
    else                  cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/adc_seq_shift.sv
// Full-duplex shifter: configuration out MSB first, result in MSB first.
module adc_seq_shift #(
  parameter int DATA_W = 12,
  parameter int CFG_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [CFG_W-1:0]  cfg_i,
  input  logic              cap_i,
  input  logic              adv_i,
  input  logic              sdo_i,
  output logic              sdi_o,
  output logic [DATA_W-1:0] rx_o
);
  logic [CFG_W-1:0]  tx_q, tx_d;
  logic [DATA_W-1:0] rx_q, rx_d;

  always_comb begin
    tx_d = tx_q;
    if (load_i)     tx_d = cfg_i;
    else if (adv_i) tx_d = tx_q << 1;
    rx_d = rx_q;
    if (cap_i)      rx_d = {rx_q[DATA_W-2:0], sdo_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q <= '0;
      rx_q <= '0;
    end else begin
      tx_q <= tx_d;
      rx_q <= rx_d;
    end
  end

  assign sdi_o = tx_q[CFG_W-1];
  assign rx_o  = rx_q;
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int CFG_W  = 2,
  parameter int DIV_W  = 8,
  parameter int WAIT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [CFG_W-1:0]  cfg_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic [WAIT_W-1:0] conv_wait_i,
  input  logic              sdo_i,
  output logic              conv_o,
  output logic              sck_o,
  output logic              sdi_o,
  output logic              busy_o,
  output logic              valid_o,
  output logic [DATA_W-1:0] result_o
);
  localparam int BCNT_W = $clog2(DATA_W);
  localparam logic [BCNT_W-1:0] LAST_BIT = BCNT_W'(DATA_W - 1);

  seq_state_t        state_q, state_d;
  logic              conv_q, conv_d, sck_q, sck_d;
  logic              busy_q, busy_d, valid_q, valid_d;
  logic [DATA_W-1:0] res_q, res_d;
  logic [WAIT_W-1:0] wcnt_q, wcnt_d, wait_q, wait_d;
  logic [DIV_W-1:0]  div_q, div_d;
  logic [BCNT_W-1:0] bcnt_q, bcnt_d;
  logic              tick, restart, load, cap, adv;
  logic [DATA_W-1:0] rx_word;

  adc_seq_tick #(.DIV_W(DIV_W)) tick_i (
    .clk(clk), .rst_n(rst_n), .restart_i(restart), .div_i(div_q), .tick_o(tick)
  );

  adc_seq_shift #(.DATA_W(DATA_W), .CFG_W(CFG_W)) shift_i (
    .clk(clk), .rst_n(rst_n), .load_i(load), .cfg_i(cfg_i), .cap_i(cap),
    .adv_i(adv), .sdo_i(sdo_i), .sdi_o(sdi_o), .rx_o(rx_word)
  );

  // next-state logic
  always_comb begin
    state_d = state_q;
    conv_d  = conv_q;
    sck_d   = sck_q;
    busy_d  = busy_q;
    valid_d = 1'b0;
    res_d   = res_q;
    wcnt_d  = wcnt_q;
    wait_d  = wait_q;
    div_d   = div_q;
    bcnt_d  = bcnt_q;
    restart = 1'b0;
    load    = 1'b0;
    cap     = 1'b0;
    adv     = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        state_d = ST_ACQ;
        conv_d  = 1'b0;
        busy_d  = 1'b1;
        restart = 1'b1;
        load    = 1'b1;
        div_d   = div_i;
        wait_d  = conv_wait_i;
        wcnt_d  = '0;
        bcnt_d  = '0;
      end
      ST_ACQ: if (tick) begin
        state_d = ST_CONV;
        conv_d  = 1'b1;
      end
      ST_CONV: if (tick) begin
        if (wcnt_q == wait_q) begin
          state_d = ST_SETUP;
          conv_d  = 1'b0;
        end else begin
          wcnt_d = wcnt_q + 1'b1;
        end
      end
      ST_SETUP, ST_SCK_LO: if (tick) begin
        state_d = ST_SCK_HI;
        sck_d   = 1'b1;
        cap     = 1'b1;
      end
      ST_SCK_HI: if (tick) begin
        sck_d = 1'b0;
        if (bcnt_q == LAST_BIT) begin
          state_d = ST_IDLE;
          conv_d  = 1'b1;
          busy_d  = 1'b0;
          valid_d = 1'b1;
          res_d   = rx_word;
        end else begin
          state_d = ST_SCK_LO;
          bcnt_d  = bcnt_q + 1'b1;
          adv     = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      conv_q  <= 1'b1;
      sck_q   <= 1'b0;
      busy_q  <= 1'b0;
      valid_q <= 1'b0;
      res_q   <= '0;
      wcnt_q  <= '0;
      wait_q  <= '0;
      div_q   <= '0;
      bcnt_q  <= '0;
    end else begin
      state_q <= state_d;
      conv_q  <= conv_d;
      sck_q   <= sck_d;
      busy_q  <= busy_d;
      valid_q <= valid_d;
      res_q   <= res_d;
      wcnt_q  <= wcnt_d;
      wait_q  <= wait_d;
      div_q   <= div_d;
      bcnt_q  <= bcnt_d;
    end
  end

  assign conv_o   = conv_q;
  assign sck_o    = sck_q;
  assign busy_o   = busy_q;
  assign valid_o  = valid_q;
  assign result_o = res_q;
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic conv_o,
  input logic sck_o,
  input logic sdi_o,
  input logic busy_o,
  input logic valid_o
);
  // R5
  sck_rise_in_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sck_o) |-> !conv_o && busy_o);
  // R4
  sck_after_low_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sck_o) |-> $past(!conv_o));
  // R8
  valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);
  // R8
  valid_at_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> conv_o && !busy_o && !sck_o);
  // R1
  idle_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> conv_o && !sck_o);
  // R9
  busy_from_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(start_i));
  // R7
  sdi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_o && $past(sck_o)) |-> $stable(sdi_o));
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .conv_o(conv_o), .sck_o(sck_o),
  .sdi_o(sdi_o), .busy_o(busy_o), .valid_o(valid_o)
);

// File: tb/adc_seq_ctrl_tb_top.sv
`timescale 1ns/1ps
module adc_seq_ctrl_tb_top;
  logic        clk, rst_n, start_i, sdo_r;
  logic [1:0]  cfg_i;
  logic [7:0]  div_i, conv_wait_i;
  logic        conv_o, sck_o, sdi_o, busy_o, valid_o;
  logic [11:0] result_o;

  adc_seq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .cfg_i(cfg_i), .div_i(div_i),
    .conv_wait_i(conv_wait_i), .sdo_i(sdo_r), .conv_o(conv_o), .sck_o(sck_o),
    .sdi_o(sdi_o), .busy_o(busy_o), .valid_o(valid_o), .result_o(result_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // converter model: data changes on strobe fall and shift-clock fall
  logic [11:0] word_q;
  int sdo_idx;
  always @(negedge conv_o) begin sdo_idx = 11; sdo_r = word_q[11]; end
  always @(negedge sck_o) if (!conv_o) begin
    sdo_idx--;
    sdo_r = (sdo_idx >= 0) ? word_q[sdo_idx] : 1'b0;
  end

  // sdi as seen by the converter at each rising shift-clock edge
  logic [11:0] sdi_seen;
  int cap_idx;
  always @(posedge sck_o) begin
    if (cap_idx < 12) sdi_seen[cap_idx] = sdi_o;
    cap_idx++;
  end

  // waveform monitor sampled away from the active edge
  int p_exp, conv_run, conv_lo_run, conv_hi_len, acq_len, setup_len;
  int sck_hi, sck_lo, rises, phase_bad, vcount;
  logic prev_conv, prev_sck;
  always @(negedge clk) begin
    if (conv_o === 1'b1 && prev_conv === 1'b0) begin
      if (rises == 0) acq_len = conv_lo_run;
      conv_run = 0;
    end
    if (conv_o === 1'b0 && prev_conv === 1'b1) begin
      conv_hi_len = conv_run; rises = 0; setup_len = 0; sck_lo = 0; conv_lo_run = 0;
    end
    if (sck_o === 1'b1 && prev_sck === 1'b0) begin
      rises++;
      if (rises == 1) setup_len = sck_lo;
      else if (sck_lo != p_exp) phase_bad++;
      sck_hi = 0;
    end
    if (sck_o === 1'b0 && prev_sck === 1'b1) begin
      if (sck_hi != p_exp) phase_bad++;
      sck_lo = 0;
    end
    if (conv_o === 1'b1) conv_run++; else conv_lo_run++;
    if (sck_o === 1'b1) sck_hi++; else sck_lo++;
    if (valid_o === 1'b1) vcount++;
    prev_conv = conv_o;
    prev_sck  = sck_o;
  end

  function automatic int exp_latency(input int dv, input int wt);
    return (wt + 26) * (dv + 1) + 1;
  endfunction
  function automatic logic [11:0] exp_cfg_bits(input logic [1:0] cf);
    return {10'b0, cf[0], cf[1]};
  endfunction

  task automatic run_txn(input logic [11:0] word, input logic [1:0] cf,
                         input int dv, input int wt, input bit poke);
    int c, lat;
    bit timed_out;
    lat = exp_latency(dv, wt);
    @(negedge clk);
    phase_bad = 0; vcount = 0; cap_idx = 0; sdi_seen = '0; p_exp = dv + 1;
    word_q = word; cfg_i = cf; div_i = 8'(dv); conv_wait_i = 8'(wt);
    start_i = 1'b1;
    c = 0; timed_out = 0;
    forever begin
      @(negedge clk);
      c++;
      if (c == 1) start_i = 1'b0;
      if (poke && c == lat / 2) begin
        chk(busy_o === 1'b1, "R2 busy mid-cycle", int'(busy_o), 1);
        start_i = 1'b1; cfg_i = ~cf; div_i = 8'(dv + 3); conv_wait_i = 8'(wt + 5);
      end
      if (poke && c == lat / 2 + 1) start_i = 1'b0;
      if (valid_o === 1'b1) break;
      if (c > 20000) begin timed_out = 1; break; end
    end
    chk(!timed_out, "R8 watchdog on valid", c, lat);
    chk(c == lat, "R8 latency", c, lat);
    chk(acq_len == p_exp, "R2 sample gap", acq_len, p_exp);
    chk(conv_hi_len == (wt + 1) * p_exp, "R3 strobe high", conv_hi_len, (wt + 1) * p_exp);
    chk(setup_len == p_exp, "R4 setup", setup_len, p_exp);
    chk(rises == 12, "R5 clock count", rises, 12);
    chk(phase_bad == 0, "R5 phase widths", phase_bad, 0);
    chk(result_o == word, "R6 result", int'(result_o), int'(word));
    chk(sdi_seen == exp_cfg_bits(cf), "R7 config bits", int'(sdi_seen), int'(exp_cfg_bits(cf)));
    chk(conv_o === 1'b1 && busy_o === 1'b0 && sck_o === 1'b0, "R8 end state",
        int'({conv_o, busy_o, sck_o}), 4);
    @(negedge clk);
    chk(valid_o === 1'b0, "R8 valid one cycle", int'(valid_o), 0);
    if (poke) begin
      repeat (3 * (dv + 4)) @(negedge clk);
      chk(busy_o === 1'b0 && vcount == 1, "R9 ignored start", vcount, 1);
      chk(rises == 12, "R10 no restart after change", rises, 12);
    end
  endtask

  initial begin
    int seed;
    seed = $urandom(32'd20240611);
    seed = 0;
    rst_n = 1'b0; start_i = 1'b0; cfg_i = '0; div_i = '0; conv_wait_i = '0;
    sdo_r = 1'b0; word_q = '0; sdo_idx = 0; cap_idx = 0; rises = 0;
    conv_run = 0; conv_lo_run = 0; sck_hi = 0; sck_lo = 0; vcount = 0; p_exp = 1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(conv_o === 1'b1 && sck_o === 1'b0 && sdi_o === 1'b0, "R1 reset pins",
        int'({conv_o, sck_o, sdi_o}), 4);
    chk(busy_o === 1'b0 && valid_o === 1'b0 && result_o === 12'h000, "R1 reset status",
        int'(result_o), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(conv_o === 1'b1 && busy_o === 1'b0, "R1 idle after reset", int'(busy_o), 0);
    // directed corners
    run_txn(12'hFFF, 2'b10, 0, 0, 0);
    run_txn(12'h800, 2'b01, 1, 3, 0);
    run_txn(12'h001, 2'b11, 7, 2, 1);
    run_txn(12'hA5C, 2'b00, 2, 10, 1);
    // random traffic
    for (int i = 0; i < 24; i++) begin
      run_txn(12'($urandom), 2'($urandom), int'($urandom_range(0, 3)),
              int'($urandom_range(0, 15)), (i % 4) == 3);
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #800000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule